// File: doc/BRIEF.md
# Edge-Timing FM Tone Demodulator

This block turns a frequency-modulated audio tone back into the 8-bit value that was used to key it. An external comparator squares the tone up, and the block receives that as a single bit. The block brings the bit into its own clock domain, removes single-sample glitches, and measures the time in clock ticks between one clean rising edge and the next. The measured period is converted into a code with a linear mapping in time. The slowest carrier, about 606 µs, gives code 0. The fastest carrier, about 408 µs, gives code 255.

A result is produced for every carrier cycle. As an option, the block can report the mean of the last 2, 4 or 8 periods instead of the newest one, which reduces noise. A period far outside the carrier band raises an error strobe and produces no code. So does a long gap with no edge. Either event also discards the averaging history. Finding the 120 Hz symbol boundaries is left to logic downstream.

Top module: `fm_period_demod`

## Requirements
- R1: While reset is held, and in the cycle after it, `code_vld_o` and `range_err_o` are 0 and `code_o` is 0.
- R2: The comparator bit passes through two synchroniser flops and then a majority-of-three filter. A pulse one clock long of either polarity produces no extra edge and does not change the measured period.
- R3: The period is the number of counter ticks between two successive filtered rising edges. The first edge after reset, or after a timeout, only starts the timing and yields neither a code nor an error.
- R4: With `avg_sel`=0, every measured period in range gives one code. Let SLOW = PER_FAST+PER_SPAN. The code is floor((SLOW − p)·255 / PER_SPAN). It is 255 for p ≤ PER_FAST and 0 for p ≥ SLOW. `code_vld_o` is high for one cycle per result.
- R5: A period below LIM_LO or above LIM_HI gives a one-cycle `range_err_o`, no code, and empties the averaging history. The next edge-to-edge interval is measured as usual.
- R6: If TIMEOUT ticks pass after an edge with no new rising edge, the block gives a one-cycle `range_err_o`, empties the averaging history, and treats the next edge as a first edge (R3).
- R7: `avg_sel` selects the averaging depth N: 0→1, 1→2, 2→4, 3→8. The code is computed from floor(sum of the newest N in-range periods / N). No code is produced until N in-range periods have been stored since the last clear. After that, every new period produces one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_in | input | 1 | Squared-up carrier from the comparator, asynchronous |
| avg_sel | input | 2 | Averaging depth select (R7 encoding) |
| code_o | output | 8 | Recovered code |
| code_vld_o | output | 1 | One-cycle strobe: `code_o` holds a new result |
| range_err_o | output | 1 | One-cycle strobe: period out of band, or timeout |

## Verification
A wrong internal state shows up at the ports within one carrier cycle of the fault. A miscounted period appears in the next code as an offset from the exact value. A stale armed flag appears as a code or error strobe on the first edge after a gap, where none is expected. A history that is not cleared after an error gives a code from fewer than N new periods, which the bench sees as an extra strobe. A glitch that gets through the filter splits one interval into two short periods and raises an error strobe at once. A scoreboard compares every strobe in order against a model of the edge intervals the bench drove. Any extra, missing or wrong result is therefore reported on the carrier cycle where it occurs.

// File: rtl/fmd_pkg.sv
// Package: shared constants and helpers for the edge-timing FM demodulator.
// Assumes: output codes are 8 bits wide; averaging depth is at most 8.
package fmd_pkg;
    localparam int CODE_W   = 8;
    localparam int CODE_MAX = 255;
    localparam int AVG_MAX  = 8;
    localparam int SEL_W    = 2;

    typedef logic [CODE_W-1:0] code_t;

    // Majority vote of three samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/fmd_input_cond.sv
// Module: fmd_input_cond
// Brings the asynchronous comparator bit into the clock domain (two flops),
// removes one-sample glitches with a majority of three, and emits a one-cycle
// pulse on each rising edge of the filtered signal.
// Assumes: each real level lasts far longer than three clocks.
module fmd_input_cond
    import fmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic       sync1, sync2;
    logic [2:0] win;
    logic       filt, filt_q;

    // Synchroniser, sample window, filtered level and its delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1  <= 1'b0;
            sync2  <= 1'b0;
            win    <= 3'b000;
            filt   <= 1'b0;
            filt_q <= 1'b0;
        end else begin
            sync1  <= din;
            sync2  <= sync1;
            win    <= {win[1:0], sync2};
            filt   <= maj3(win[0], win[1], win[2]);
            filt_q <= filt;
        end
    end

    // Rising edge of the filtered level.
    assign rise = filt & ~filt_q;

    // R2: a qualified edge never repeats on the next cycle
    a_r2_rise_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fmd_period_timer.sv
// Module: fmd_period_timer
// Counts ticks between qualified rising edges. It reports each in-band period,
// flags out-of-band periods, and flags a timeout when no edge arrives.
// The first edge after reset or timeout only arms the counter.
// Assumes: TIMEOUT > LIM_HI, and CNT_W can hold TIMEOUT.
module fmd_period_timer #(
    parameter int TICK_DIV = 10,
    parameter int LIM_LO   = 3800,
    parameter int LIM_HI   = 6400,
    parameter int TIMEOUT  = 10000,
    parameter int CNT_W    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] per_o,
    output logic             per_vld_o,
    output logic             err_o
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LIM_LO);
    localparam logic [CNT_W-1:0] HI_C  = CNT_W'(LIM_HI);
    localparam logic [CNT_W-1:0] TO_C  = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic             tick;
    logic             armed;
    logic [CNT_W-1:0] cnt;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_q;
            // Prescaler: one tick every TICK_DIV clocks.
            always_ff @(posedge clk) begin
                if (!rst_n || div_q == DIV_W'(TICK_DIV - 1)) div_q <= '0;
                else                                         div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIV_W'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    // Edge-to-edge counting, range check and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            cnt       <= '0;
            per_o     <= '0;
            per_vld_o <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            per_vld_o <= 1'b0;
            err_o     <= 1'b0;
            if (rise) begin
                if (armed) begin
                    if (cnt < LO_C || cnt > HI_C) begin
                        err_o <= 1'b1;
                    end else begin
                        per_o     <= cnt;
                        per_vld_o <= 1'b1;
                    end
                end
                armed <= 1'b1;
                cnt   <= tick ? ONE_C : '0;
            end else if (armed) begin
                if (cnt >= TO_C) begin
                    err_o <= 1'b1;
                    armed <= 1'b0;
                    cnt   <= '0;
                end else if (tick) begin
                    cnt <= cnt + ONE_C;
                end
            end
        end
    end

    // R6: while armed the count never passes the timeout limit
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt <= TO_C));
    // R3: an arming edge yields neither a period nor an error
    a_r3_first_edge_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !armed) |=> (!per_vld_o && !err_o));
endmodule

// File: rtl/fmd_avg.sv
// Module: fmd_avg
// Keeps the newest eight in-band periods and reports the mean of the newest
// N (N = 1, 2, 4 or 8), once at least N periods have arrived since the last clear.
// Assumes: clr and in_vld never coincide; sel is held while periods stream.
module fmd_avg
    import fmd_pkg::*;
#(
    parameter int W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     in_per,
    input  logic             in_vld,
    output logic [W-1:0]     out_per,
    output logic             out_vld
);
    localparam int SW = W + $clog2(AVG_MAX);
    localparam int FW = $clog2(AVG_MAX) + 1;

    logic [W-1:0]  hist [AVG_MAX];
    logic [FW-1:0] fill;
    logic          pend;
    logic [SW-1:0] sum;
    logic [FW-1:0] need;

    generate
        for (genvar k = 0; k < AVG_MAX; k++) begin : g_hist
            // History slot k: shifts one place older on each new period.
            always_ff @(posedge clk) begin
                if (!rst_n)      hist[k] <= '0;
                else if (in_vld) hist[k] <= (k == 0) ? in_per : hist[(k == 0) ? 0 : k-1];
            end
        end
    endgenerate

    // Number of periods the selected depth needs.
    assign need = FW'(1) << sel;

    // Sum of the newest N periods.
    always_comb begin
        sum = '0;
        for (int i = 0; i < AVG_MAX; i++) begin
            if (FW'(i) < need) sum = sum + SW'(hist[i]);
        end
    end

    // Fill count, pending flag and mean output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill    <= '0;
            pend    <= 1'b0;
            out_vld <= 1'b0;
            out_per <= '0;
        end else if (clr) begin
            fill    <= '0;
            pend    <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            pend    <= in_vld;
            out_vld <= pend && (fill >= need);
            if (in_vld && fill < FW'(AVG_MAX)) fill <= fill + 1'b1;
            if (pend) out_per <= W'(sum >> sel);
        end
    end

    // R7: a clear suppresses any result on the following cycle
    a_r7_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !out_vld);
    // R7: fill count saturates at the history depth
    a_r7_fill_sat: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(AVG_MAX));
endmodule

// File: rtl/fmd_code_map.sv
// Module: fmd_code_map
// Maps a period to an 8-bit code that is linear in time. The division by the
// span is done as a multiply by a rounded-up reciprocal and a right shift.
// Assumes: PER_SPAN^2 < 2^FRAC_SH, so the reciprocal floor matches exact division.
module fmd_code_map
    import fmd_pkg::*;
#(
    parameter int W        = 14,
    parameter int PER_FAST = 4080,
    parameter int PER_SPAN = 1980,
    parameter int LIM_LO   = 3800,
    parameter int LIM_HI   = 6400,
    parameter int FRAC_SH  = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_per,
    input  logic         in_vld,
    output code_t        code_o,
    output logic         code_vld_o
);
    localparam int PER_SLOW = PER_FAST + PER_SPAN;
    localparam int DW = $clog2(PER_SPAN + 1);
    localparam int KW = FRAC_SH + CODE_W + 1;
    localparam int PW = DW + KW;
    localparam logic [63:0] K_FULL =
        ((64'(CODE_MAX) << FRAC_SH) + 64'(PER_SPAN) - 64'd1) / 64'(PER_SPAN);
    localparam logic [W-1:0]  SLOW_C = W'(PER_SLOW);
    localparam logic [W-1:0]  FAST_C = W'(PER_FAST);
    localparam logic [KW-1:0] K_C    = KW'(K_FULL);

    logic [DW-1:0] diff;
    logic [PW-1:0] prod;
    code_t         code_n;

    // Clamp at both ends, otherwise scale the distance from the slow end.
    always_comb begin
        diff = DW'(SLOW_C - in_per);
        prod = PW'(diff) * PW'(K_C);
        if (in_per >= SLOW_C)      code_n = '0;
        else if (in_per <= FAST_C) code_n = code_t'(CODE_MAX);
        else                       code_n = prod[FRAC_SH +: CODE_W];
    end

    // Registered code and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o     <= '0;
            code_vld_o <= 1'b0;
        end else begin
            code_vld_o <= in_vld;
            if (in_vld) code_o <= code_n;
        end
    end

    // R5: only in-band periods reach the mapping
    a_r5_avg_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> (in_per >= W'(LIM_LO) && in_per <= W'(LIM_HI)));
    // R4: at most one result strobe per burst
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |=> !code_vld_o);
endmodule

// File: rtl/fm_period_demod.sv
// Module: fm_period_demod (top)
// Recovers an 8-bit code from a squared-up FM tone by timing edge to edge,
// with optional averaging and a band/timeout error strobe.
// Assumes: default timing is a 10 MHz tick (TICK_DIV clocks per tick).
module fm_period_demod
    import fmd_pkg::*;
#(
    parameter int TICK_DIV = 10,
    parameter int PER_FAST = 4080,
    parameter int PER_SPAN = 1980,
    parameter int LIM_LO   = 3800,
    parameter int LIM_HI   = 6400,
    parameter int TIMEOUT  = 10000,
    parameter int FRAC_SH  = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_in,
    input  logic [1:0] avg_sel,
    output logic [7:0] code_o,
    output logic       code_vld_o,
    output logic       range_err_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic             rise;
    logic [CNT_W-1:0] per, avg_per;
    logic             per_vld, avg_vld, err;

    fmd_input_cond u_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_in),
        .rise (rise)
    );

    fmd_period_timer #(
        .TICK_DIV(TICK_DIV), .LIM_LO(LIM_LO), .LIM_HI(LIM_HI),
        .TIMEOUT (TIMEOUT),  .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .per_o    (per),
        .per_vld_o(per_vld),
        .err_o    (err)
    );

    fmd_avg #(.W(CNT_W)) u_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (err),
        .sel    (avg_sel),
        .in_per (per),
        .in_vld (per_vld),
        .out_per(avg_per),
        .out_vld(avg_vld)
    );

    fmd_code_map #(
        .W(CNT_W), .PER_FAST(PER_FAST), .PER_SPAN(PER_SPAN),
        .LIM_LO(LIM_LO), .LIM_HI(LIM_HI), .FRAC_SH(FRAC_SH)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_per    (avg_per),
        .in_vld    (avg_vld),
        .code_o    (code_o),
        .code_vld_o(code_vld_o)
    );

    assign range_err_o = err;

    // R1: outputs are quiet in the cycle after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!code_vld_o && !range_err_o && code_o == 8'd0));
    // R5: an error strobe never comes with a code strobe
    a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |-> !code_vld_o);
endmodule

// File: tb/test_fm_period_demod.sv
// Scoreboard bench: driver tasks model each edge interval and push the
// expected results; a monitor pops and compares each strobe.
module test_fm_period_demod;
    localparam int PF = 408, SP = 198, LL = 380, LH = 640, TO = 1000;
    localparam int SLOW = PF + SP;

    typedef struct {
        bit    is_err;
        int    code;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_in = 1'b0;
    logic [1:0] avg_sel = 2'd0;
    logic [7:0] code_o;
    logic       code_vld_o, range_err_o;

    int    total = 0, bad = 0;
    exp_t  sbq[$];
    int    hist[$];
    bit    armed = 0;
    int    prev_len = 0;
    string prev_tag = "";
    int    depth = 1;
    bit    done = 0;

    always #5 clk = ~clk;

    fm_period_demod #(
        .TICK_DIV(1), .PER_FAST(PF), .PER_SPAN(SP),
        .LIM_LO(LL), .LIM_HI(LH), .TIMEOUT(TO), .FRAC_SH(24)
    ) i_fm_period_demod (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .avg_sel(avg_sel),
        .code_o(code_o), .code_vld_o(code_vld_o), .range_err_o(range_err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int map_code(input int p);
        if (p >= SLOW) return 0;
        if (p <= PF)   return 255;
        return ((SLOW - p) * 255) / SP;
    endfunction

    // Model of one closed interval, per R4, R5, R7.
    task automatic judge(input int p, input string tag);
        exp_t e;
        if (p < LL || p > LH) begin
            e.is_err = 1; e.code = 0; e.req = tag;
            sbq.push_back(e);
            hist.delete();
        end else begin
            int s;
            hist.push_front(p);
            if (hist.size() > 8) void'(hist.pop_back());
            if (hist.size() >= depth) begin
                s = 0;
                for (int i = 0; i < depth; i++) s += hist[i];
                e.is_err = 0; e.code = map_code(s / depth); e.req = tag;
                sbq.push_back(e);
            end
        end
    endtask

    task automatic edge_model();
        if (armed) judge(prev_len, prev_tag);
        armed = 1;
    endtask

    // One carrier cycle starting with a rising edge.
    task automatic tone(input int per, input string tag);
        edge_model();
        for (int i = 0; i < per; i++) begin
            @(negedge clk);
            cmp_in = (i < per / 2);
        end
        prev_len = per;
        prev_tag = tag;
    endtask

    // One carrier cycle with a one-clock dropout in each half (R2).
    task automatic tone_glitch(input int per, input string tag);
        edge_model();
        for (int i = 0; i < per; i++) begin
            @(negedge clk);
            cmp_in = (i < per / 2);
            if (i == per / 4 || i == (3 * per) / 4) cmp_in = ~cmp_in;
        end
        prev_len = per;
        prev_tag = tag;
    endtask

    // Hold the input low; a timeout fires if armed (R6).
    task automatic silence(input int n);
        exp_t e;
        if (armed && prev_len + n > TO + 10) begin
            e.is_err = 1; e.code = 0; e.req = "R6";
            sbq.push_back(e);
            armed = 0;
            hist.delete();
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_in = 1'b0;
        end
    endtask

    // Monitor: pop and compare on each strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (code_vld_o || range_err_o)) begin
                if (code_vld_o && range_err_o) begin
                    check(0, "R5", "code and error together", 1, 0);
                end else if (sbq.size() == 0) begin
                    check(0, "R3", "unexpected strobe code", int'(code_o), -1);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (e.is_err)
                        check(range_err_o, e.req, "error strobe", int'(range_err_o), 1);
                    else begin
                        check(code_vld_o, e.req, "code strobe", int'(code_vld_o), 1);
                        check(int'(code_o) == e.code, e.req, "code value", int'(code_o), e.code);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(0, "R1", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(code_vld_o == 0 && range_err_o == 0, "R1", "strobes in reset",
              int'(code_vld_o) + int'(range_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(code_o == 8'd0 && !code_vld_o && !range_err_o, "R1", "state after reset",
              int'(code_o), 0);

        // Depth 1: mapping, clamps, band errors, glitches.
        depth = 1; avg_sel = 2'd0;
        silence(300);
        tone(500, "R3");
        tone(408, "R4"); tone(606, "R4"); tone(507, "R4"); tone(450, "R4");
        tone(600, "R4"); tone(380, "R4"); tone(640, "R4");
        tone(379, "R5"); tone(641, "R5"); tone(700, "R5"); tone(520, "R5");
        tone_glitch(480, "R2"); tone_glitch(560, "R2"); tone(430, "R4");
        silence(1500);

        // Depth 4 with a clear in the middle.
        depth = 4; avg_sel = 2'd2;
        tone(500, "R7"); tone(510, "R7"); tone(520, "R7"); tone(530, "R7");
        tone(540, "R7"); tone(560, "R7"); tone(700, "R5");
        tone(450, "R7"); tone(460, "R7"); tone(470, "R7"); tone(480, "R7");
        tone(490, "R7");
        silence(1500);

        // Depth 8.
        depth = 8; avg_sel = 2'd3;
        for (int k = 0; k < 11; k++) tone(410 + 19 * k, "R7");
        silence(1500);

        // Depth 2, arming after timeout again.
        depth = 2; avg_sel = 2'd1;
        tone(420, "R3"); tone(590, "R7"); tone(411, "R7"); tone(603, "R7");
        silence(1500);

        repeat (20) @(negedge clk);
        check(sbq.size() == 0, "R3", "results missing at end", sbq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule